// File: doc/BRIEF.md
# Step Attenuator Control Latch

This block holds the six-bit control word of a 0.25 dB step attenuator that is driven over a parallel interface. Six active-low control pins choose which attenuation steps are inserted. A latch-enable pin either lets the word pass through directly, or freezes it so that a new word is taken only when enable is pulsed. A mode-select pin must be low for any parallel update to occur. When it is high, the applied word stays where it is.

After reset, a counter waits a configurable number of clock cycles, sized for about 200 ms of settling. Until it expires, the applied word is all ones (no attenuation) and the ready flag is low. When it expires, one initial word is committed. If latch enable is high at that moment, the word comes from the six control pins. If it is low, the word comes from a four-entry table selected by two preset pins.

All pins pass through one register stage before the control state machine. The machine has four states:
- `ST_POWER_WAIT`: the settling delay is running.
- `ST_FOLLOW`: transparent operation.
- `ST_LOCKED`: latch closed.
- `ST_FROZEN`: mode-select high.

Its transitions are:
- **commit**: `ST_POWER_WAIT` to one of the three operating states once the delay expires.
- **open**: any operating state to `ST_FOLLOW` when enable is high and mode-select is low.
- **close**: to `ST_LOCKED` when enable is low and mode-select is low.
- **freeze**: to `ST_FROZEN` whenever mode-select is high.

Top module: `atten_ctrl_latch`

## Requirements
- R1: While reset is asserted, and after reset until the power-up delay expires, `att_word_o` is all ones and `ready_o` is 0.
- R2: With the delay parameter set to D cycles, `ready_o` is still 0 after D rising clock edges following reset release, and it is 1 after D+1 edges.
- R3: If latch enable is low when the delay expires, the committed word follows the preset pins (a, b). (0,0) gives 6'b000000 (15.75 dB). (1,0) gives 6'b001111 (12 dB). (0,1) gives 6'b011111 (8 dB). (1,1) gives 6'b111111 (0 dB).
- R4: If latch enable is high when the delay expires, the committed word equals the control pins as sampled at that edge.
- R5: With mode-select low and latch enable high, `att_word_o` equals the control pins with a latency of two clock edges.
- R6: With mode-select low and latch enable low, `att_word_o` does not change, whatever the control pins do.
- R7: After a latch-enable pulse, the held word is the last control word sampled while enable was high. A control change sampled in the same cycle as the enable falling is not taken.
- R8: While mode-select is high, `att_word_o` holds its value regardless of enable and control pins. Once it returns low, normal parallel operation resumes.
- R9: Bit i, when 0, inserts 2^i quarter-dB steps. The attenuation of a word is the sum of the weights of its zero bits: all ones is 0 dB and all zeros is 15.75 dB.
- R10: Once `ready_o` rises, it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ser_sel_i | input | 1 | Mode select; high blocks parallel updates |
| latch_en_i | input | 1 | Latch enable; high is transparent, low holds |
| ctrl_i | input | 6 | Active-low attenuation control bits |
| preset_a_i | input | 1 | First power-up preset pin |
| preset_b_i | input | 1 | Second power-up preset pin |
| att_word_o | output | 6 | Applied attenuation word (active low) |
| ready_o | output | 1 | High once the power-up word is committed |

## Verification
Two events can share a clock cycle.

The first is the latch closing while the control word changes. The bench lowers enable and drives a new word on the same falling clock edge. It judges the result correct only if the previously applied word stays in place.

The second is the power-up commit coinciding with a change on the control pins. The bench changes the word one cycle before the delay expires, then checks that the committed value is the newly sampled one. Sweeps over all 64 control words and all four preset codes surround these cases. Expected words and their quarter-dB sums are computed arithmetically in the bench.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int ATT_BITS = 6;

    typedef enum logic [1:0] {
        ST_POWER_WAIT = 2'd0,
        ST_FOLLOW     = 2'd1,
        ST_LOCKED     = 2'd2,
        ST_FROZEN     = 2'd3
    } att_state_e;

endpackage

// File: rtl/atten_in_sample.sv
module atten_in_sample #(
    parameter int W = atten_pkg::ATT_BITS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         ser_sel_i,
    input  logic         latch_en_i,
    input  logic [W-1:0] ctrl_i,
    input  logic         preset_a_i,
    input  logic         preset_b_i,
    output logic         ser_q,
    output logic         le_q,
    output logic [W-1:0] ctrl_q,
    output logic [1:0]   preset_q
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ser_q    <= 1'b0;
            le_q     <= 1'b0;
            ctrl_q   <= '1;
            preset_q <= 2'b11;
        end else begin
            ser_q    <= ser_sel_i;
            le_q     <= latch_en_i;
            ctrl_q   <= ctrl_i;
            preset_q <= {preset_b_i, preset_a_i};
        end
    end

endmodule

// File: rtl/atten_pwr_timer.sv
module atten_pwr_timer #(
    parameter int DELAY_CYCLES = 25_000_000
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic expired_o
);

    localparam int CW = $clog2(DELAY_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DELAY_CYCLES);

    logic [CW-1:0] count_q;

    assign expired_o = (count_q == LIMIT);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            count_q <= '0;
        end else if (!expired_o) begin
            count_q <= count_q + 1'b1;
        end
    end

    // R2: once expired, the timer never leaves that condition
    a_r2_expiry_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expired_o |=> expired_o);

    a_r2_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_q <= LIMIT);

endmodule

// File: rtl/atten_latch_fsm.sv
module atten_latch_fsm
    import atten_pkg::*;
#(
    parameter int W = ATT_BITS
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         expired_i,
    input  logic         ser_q,
    input  logic         le_q,
    input  logic [W-1:0] ctrl_q,
    input  logic [1:0]   preset_q,
    output logic [W-1:0] att_word_o,
    output logic         ready_o
);

    localparam logic [W-1:0] WORD_ZERO_DB = '1;
    localparam logic [W-1:0] WORD_MAX_DB  = '0;
    localparam logic [W-1:0] WORD_TOP_ONE = ~(W'(1) << (W - 1));
    localparam logic [W-1:0] WORD_TOP_TWO = ~(W'(3) << (W - 2));

    att_state_e state_q, state_d;
    logic [W-1:0] preset_word;
    logic         open_path;

    // preset_q = {b, a}
    always_comb begin
        unique case (preset_q)
            2'b00:   preset_word = WORD_MAX_DB;
            2'b01:   preset_word = WORD_TOP_TWO;
            2'b10:   preset_word = WORD_TOP_ONE;
            default: preset_word = WORD_ZERO_DB;
        endcase
    end

    assign open_path = !ser_q && le_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWER_WAIT: begin
                if (expired_i) begin
                    if (ser_q)     state_d = ST_FROZEN;
                    else if (le_q) state_d = ST_FOLLOW;
                    else           state_d = ST_LOCKED;
                end
            end
            ST_FOLLOW, ST_LOCKED, ST_FROZEN: begin
                if (ser_q)     state_d = ST_FROZEN;
                else if (le_q) state_d = ST_FOLLOW;
                else           state_d = ST_LOCKED;
            end
            default: state_d = ST_POWER_WAIT;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_POWER_WAIT;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            att_word_o <= WORD_ZERO_DB;
            ready_o    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_POWER_WAIT: begin
                    if (expired_i) begin
                        att_word_o <= le_q ? ctrl_q : preset_word;
                        ready_o    <= 1'b1;
                    end
                end
                ST_FOLLOW, ST_LOCKED, ST_FROZEN: begin
                    if (open_path) att_word_o <= ctrl_q;
                end
                default: att_word_o <= att_word_o;
            endcase
        end
    end

    // R1: no attenuation before the power-up word is committed
    a_r1_min_atten_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> att_word_o == WORD_ZERO_DB);

    // R2: the commit happens only on an expired timer
    a_r2_commit_needs_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(expired_i));

    // R5: transparent path follows the sampled pins
    a_r5_follow_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && !ser_q && le_q) |=> att_word_o == $past(ctrl_q));

    // R6 and R8: closed latch or serial select keeps the word unchanged
    a_r6_hold_when_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && (ser_q || !le_q)) |=> $stable(att_word_o));

    // R10: ready is sticky
    a_r10_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> ready_o);

endmodule

// File: rtl/atten_ctrl_latch.sv
module atten_ctrl_latch #(
    parameter int ATT_W        = atten_pkg::ATT_BITS,
    parameter int DELAY_CYCLES = 25_000_000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ser_sel_i,
    input  logic             latch_en_i,
    input  logic [ATT_W-1:0] ctrl_i,
    input  logic             preset_a_i,
    input  logic             preset_b_i,
    output logic [ATT_W-1:0] att_word_o,
    output logic             ready_o
);

    logic             ser_q;
    logic             le_q;
    logic [ATT_W-1:0] ctrl_q;
    logic [1:0]       preset_q;
    logic             expired;

    atten_in_sample #(.W(ATT_W)) sample_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ser_sel_i  (ser_sel_i),
        .latch_en_i (latch_en_i),
        .ctrl_i     (ctrl_i),
        .preset_a_i (preset_a_i),
        .preset_b_i (preset_b_i),
        .ser_q      (ser_q),
        .le_q       (le_q),
        .ctrl_q     (ctrl_q),
        .preset_q   (preset_q)
    );

    atten_pwr_timer #(.DELAY_CYCLES(DELAY_CYCLES)) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .expired_o (expired)
    );

    atten_latch_fsm #(.W(ATT_W)) fsm_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .expired_i  (expired),
        .ser_q      (ser_q),
        .le_q       (le_q),
        .ctrl_q     (ctrl_q),
        .preset_q   (preset_q),
        .att_word_o (att_word_o),
        .ready_o    (ready_o)
    );

endmodule

// File: tb/atten_ctrl_latch_tb_top.sv
`timescale 1ns/1ps
module atten_ctrl_latch_tb_top;

    localparam int DLY = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_sel = 1'b0;
    logic       le = 1'b0;
    logic [5:0] ctrl = 6'h3F;
    logic       pa = 1'b1;
    logic       pb = 1'b1;
    logic [5:0] word;
    logic       ready;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    atten_ctrl_latch #(.ATT_W(6), .DELAY_CYCLES(DLY)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .ser_sel_i  (ser_sel),
        .latch_en_i (le),
        .ctrl_i     (ctrl),
        .preset_a_i (pa),
        .preset_b_i (pb),
        .att_word_o (word),
        .ready_o    (ready)
    );

    function automatic int qdb(input logic [5:0] w);
        int s = 0;
        for (int i = 0; i < 6; i++) if (!w[i]) s += (1 << i);
        return s;
    endfunction

    function automatic int preset_qdb(input logic a, input logic b);
        if (!a && !b) return 63;
        if (a && !b)  return 48;
        if (!a && b)  return 32;
        return 0;
    endfunction

    task automatic chk(input int got, input int exp, input string req);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic powerup(input logic le_v, input logic a, input logic b, input logic [5:0] dv);
        @(negedge clk);
        rst_n = 1'b0;
        le = le_v; pa = a; pb = b; ctrl = dv; ser_sel = 1'b0;
        step(2);
        chk(word, 63, "R1 reset word");
        chk(ready, 0, "R1 reset ready");
        rst_n = 1'b1;
        step(DLY);
        chk(ready, 0, "R2 ready before expiry");
        chk(word, 63, "R1 word before expiry");
        step(1);
        chk(ready, 1, "R2 ready at expiry");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0] held;
        // R3: preset table, all four codes
        for (int k = 0; k < 4; k++) begin
            powerup(1'b0, k[0], k[1], 6'h15);
            chk(word, 63 - preset_qdb(k[0], k[1]), "R3 preset word");
            chk(qdb(word), preset_qdb(k[0], k[1]), "R9 preset attenuation");
        end
        // R4: power-up word from control pins
        for (int k = 0; k < 8; k++) begin
            powerup(1'b1, 1'b0, 1'b0, 6'(k * 9));
            chk(word, k * 9, "R4 pin power-up word");
        end
        // R4: control change sampled at the expiry edge is committed
        @(negedge clk);
        rst_n = 1'b0; le = 1'b1; ctrl = 6'h01;
        step(2);
        rst_n = 1'b1;
        step(DLY - 1);
        ctrl = 6'h2E;
        step(1);
        chk(ready, 0, "R2 ready before expiry");
        step(1);
        chk(word, 6'h2E, "R4 commit with coincident change");
        // R5/R9: transparent sweep
        for (int v = 0; v < 64; v++) begin
            ctrl = 6'(v);
            step(2);
            chk(word, v, "R5 transparent follow");
            chk(qdb(word), 63 - v, "R9 weight sum");
        end
        // R6/R7: latch closes while data changes
        ctrl = 6'h12;
        step(2);
        le = 1'b0; ctrl = 6'h2D;
        step(2);
        chk(word, 6'h12, "R7 close with coincident change");
        for (int v = 0; v < 6; v++) begin
            ctrl = 6'(v * 11 + 3);
            step(1);
            chk(word, 6'h12, "R6 hold while closed");
        end
        // R7: one-cycle pulse
        le = 1'b1; ctrl = 6'h07;
        step(1);
        le = 1'b0; ctrl = 6'h30;
        step(2);
        chk(word, 6'h07, "R7 pulse capture");
        step(3);
        chk(word, 6'h07, "R6 hold after pulse");
        // R8: serial select freezes
        ser_sel = 1'b1; le = 1'b1; ctrl = 6'h3C;
        held = word;
        for (int v = 0; v < 5; v++) begin
            step(1);
            chk(word, held, "R8 frozen word");
            ctrl = 6'(v * 7);
        end
        ctrl = 6'h3C;
        ser_sel = 1'b0;
        step(2);
        chk(word, 6'h3C, "R8 resume after release");
        chk(ready, 1, "R10 ready sticky");
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule